// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block holds the program-counter chain of an in-order core with one branch delay slot. The chain has three entries: the address of the instruction now retiring, the next address (the delay slot when the current instruction is a control transfer), and the address after that. Each retiring instruction moves the chain forward. The instruction's control class, its condition result, its displacement or register target, and its likely and link qualifiers decide where the chain goes.

A taken direct branch points the third entry at the next address plus the displacement, so the delay slot still executes. A conditional branch that is not taken lets the sequence run on through the delay slot. The likely form works differently: when it is not taken, the block steps the chain one extra place so the delay slot is skipped, and it raises an annul pulse so the surrounding pipeline can squash that slot. A register jump loads its target into the third entry. For any control instruction with linking, the block gives a write enable and data for the return register. The data is the third entry's value before the target is applied, which is the address just past the delay slot.

Fetch, decode, condition evaluation and hazard handling sit outside the block. It sees only one retire strobe with its qualifiers per cycle.

Top module: `pc_seq_top`

## Requirements
- R1: While rst_ni is low, and right after it rises, pc_o=RESET_PC, npc_o=RESET_PC+STEP and nnpc_o=RESET_PC+2*STEP (0, 4 and 8 by default).
- R2: When valid_i=1 and ctrl_i=0 (no control transfer), the next edge gives pc_o←npc_o, npc_o←nnpc_o and nnpc_o←nnpc_o+STEP.
- R3: When valid_i=1, ctrl_i=1 (conditional direct branch) and cond_i=1, the next edge gives pc_o←npc_o, npc_o←npc_o+disp_i and nnpc_o←npc_o+disp_i+STEP.
- R4: When valid_i=1, ctrl_i=1, cond_i=0 and likely_i=0, the chain shifts as in R2 and annul_o stays 0.
- R5: When valid_i=1, ctrl_i=1, cond_i=0 and likely_i=1, annul_o is 1 in that cycle and the next edge gives pc_o←nnpc_o, npc_o←nnpc_o+STEP and nnpc_o←nnpc_o+2*STEP. In every other case annul_o is 0.
- R6: link_we_o is 1 in exactly the cycles where valid_i=1, link_i=1 and ctrl_i≠0. In those cycles link_data_o equals the current nnpc_o.
- R7: When valid_i=1 and ctrl_i=3 (register jump), the next edge gives pc_o←npc_o, npc_o←T and nnpc_o←T+STEP. T is target_i with its low log2(STEP) bits cleared. cond_i and likely_i have no effect.
- R8: When valid_i=0, the chain holds its values and link_we_o and annul_o are 0.
- R9: When valid_i=1 and ctrl_i=2 (unconditional direct branch), the block behaves as in R3 whatever cond_i and likely_i are, and it never annuls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An instruction retires this cycle |
| ctrl_i | input | 2 | Control class: 0 none, 1 conditional branch, 2 unconditional branch, 3 register jump |
| likely_i | input | 1 | Branch is of the likely form (annul the slot when not taken) |
| link_i | input | 1 | Write the return address to the link register |
| cond_i | input | 1 | Evaluated branch condition |
| disp_i | input | XLEN | Sign-extended byte displacement |
| target_i | input | XLEN | Register jump target |
| pc_o | output | XLEN | Current PC |
| npc_o | output | XLEN | Next PC |
| nnpc_o | output | XLEN | PC after next |
| link_we_o | output | 1 | Link register write enable |
| link_data_o | output | XLEN | Return address to write |
| annul_o | output | 1 | Squash the delay-slot instruction |

## Verification
The bench sweeps every combination of valid, control class, likely, link and condition. It repeats the sweep with several positive and negative displacements and with jump targets that have their low bits set. Because the chain carries over between steps, each pattern starts from a different position left by the step before it. The sweep tells four cases apart: a plain shift, a taken redirect that keeps the delay slot, a not-taken likely skip, and the cases where a qualifier must be ignored (likely on an unconditional branch or a jump, link with no control class, any strobe with valid low). Misaligned targets show whether the jump path clears the low bits.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [1:0] {
    CT_NONE      = 2'd0,
    CT_BR_COND   = 2'd1,
    CT_BR_UNCOND = 2'd2,
    CT_JUMP      = 2'd3
  } ctl_kind_e;
endpackage

// File: rtl/pc_seq_resolve.sv
module pc_seq_resolve
  import pc_seq_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input  logic            valid_i,
  input  ctl_kind_e       kind_i,
  input  logic            likely_i,
  input  logic            cond_i,
  input  logic [XLEN-1:0] disp_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [XLEN-1:0] npc_i,
  input  logic [XLEN-1:0] nnpc_i,
  output logic [XLEN-1:0] r_npc_o,
  output logic [XLEN-1:0] r_nnpc_o,
  output logic            annul_o
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~(XLEN'(STEP - 1));

  logic taken, skip;

  always_comb begin
    taken = (kind_i == CT_BR_UNCOND) || ((kind_i == CT_BR_COND) && cond_i);
    skip  = (kind_i == CT_BR_COND) && likely_i && !cond_i;
  end

  always_comb begin
    r_npc_o = skip ? nnpc_i : npc_i;
    if (kind_i == CT_JUMP)  r_nnpc_o = target_i & ALIGN_MASK;
    else if (taken)         r_nnpc_o = npc_i + disp_i;
    else if (skip)          r_nnpc_o = nnpc_i + STEP_V;  // extra step past the slot
    else                    r_nnpc_o = nnpc_i;
  end

  assign annul_o = valid_i && skip;
endmodule

// File: rtl/pc_seq_chain.sv
module pc_seq_chain #(
  parameter int              XLEN     = 32,
  parameter int              STEP     = 4,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic [XLEN-1:0] r_npc_i,
  input  logic [XLEN-1:0] r_nnpc_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] npc_o,
  output logic [XLEN-1:0] nnpc_o
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_o   <= RESET_PC;
      npc_o  <= RESET_PC + STEP_V;
      nnpc_o <= RESET_PC + 2 * STEP_V;
    end else if (adv_i) begin
      pc_o   <= r_npc_i;
      npc_o  <= r_nnpc_i;
      nnpc_o <= r_nnpc_i + STEP_V;
    end
  end
endmodule

// File: rtl/pc_seq_link.sv
module pc_seq_link
  import pc_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            valid_i,
  input  ctl_kind_e       kind_i,
  input  logic            link_i,
  input  logic [XLEN-1:0] nnpc_i,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_data_o
);
  // return address is captured before any redirect lands in the chain
  assign link_we_o   = valid_i && link_i && (kind_i != CT_NONE);
  assign link_data_o = nnpc_i;
endmodule

// File: rtl/pc_seq_top.sv
module pc_seq_top
  import pc_seq_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              STEP     = 4,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [1:0]      ctrl_i,
  input  logic            likely_i,
  input  logic            link_i,
  input  logic            cond_i,
  input  logic [XLEN-1:0] disp_i,
  input  logic [XLEN-1:0] target_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] npc_o,
  output logic [XLEN-1:0] nnpc_o,
  output logic            link_we_o,
  output logic [XLEN-1:0] link_data_o,
  output logic            annul_o
);
  ctl_kind_e       kind;
  logic [XLEN-1:0] r_npc, r_nnpc;

  assign kind = ctl_kind_e'(ctrl_i);

  pc_seq_resolve #(.XLEN(XLEN), .STEP(STEP)) u_resolve (
    .valid_i  (valid_i),
    .kind_i   (kind),
    .likely_i (likely_i),
    .cond_i   (cond_i),
    .disp_i   (disp_i),
    .target_i (target_i),
    .npc_i    (npc_o),
    .nnpc_i   (nnpc_o),
    .r_npc_o  (r_npc),
    .r_nnpc_o (r_nnpc),
    .annul_o  (annul_o)
  );

  pc_seq_chain #(.XLEN(XLEN), .STEP(STEP), .RESET_PC(RESET_PC)) u_chain (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (valid_i),
    .r_npc_i  (r_npc),
    .r_nnpc_i (r_nnpc),
    .pc_o     (pc_o),
    .npc_o    (npc_o),
    .nnpc_o   (nnpc_o)
  );

  pc_seq_link #(.XLEN(XLEN)) u_link (
    .valid_i     (valid_i),
    .kind_i      (kind),
    .link_i      (link_i),
    .nnpc_i      (nnpc_o),
    .link_we_o   (link_we_o),
    .link_data_o (link_data_o)
  );
endmodule

// File: rtl/pc_seq_checker.sv
module pc_seq_checker #(
  parameter int XLEN = 32,
  parameter int STEP = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [1:0]      ctrl_i,
  input logic            likely_i,
  input logic            link_i,
  input logic            cond_i,
  input logic [XLEN-1:0] disp_i,
  input logic [XLEN-1:0] target_i,
  input logic [XLEN-1:0] pc_o,
  input logic [XLEN-1:0] npc_o,
  input logic [XLEN-1:0] nnpc_o,
  input logic            link_we_o,
  input logic [XLEN-1:0] link_data_o,
  input logic            annul_o
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  p_shift_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctrl_i == 2'd0) |=>
      (pc_o == $past(npc_o) && npc_o == $past(nnpc_o) && nnpc_o == $past(nnpc_o) + STEP_V));

  p_uncond_taken_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctrl_i == 2'd2) |=>
      (pc_o == $past(npc_o) && npc_o == $past(npc_o) + $past(disp_i)));

  p_annul_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    annul_o |-> (valid_i && ctrl_i == 2'd1 && likely_i && !cond_i));

  p_annul_skip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    annul_o |=> (pc_o == $past(nnpc_o) && npc_o == $past(nnpc_o) + STEP_V));

  p_link_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> (link_data_o == nnpc_o && valid_i && link_i && ctrl_i != 2'd0));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(pc_o) && $stable(npc_o) && $stable(nnpc_o)));

  p_jump_align_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ctrl_i == 2'd3) |=> ((npc_o & XLEN'(STEP - 1)) == '0 && pc_o == $past(npc_o)));
endmodule

bind pc_seq_top pc_seq_checker #(.XLEN(XLEN), .STEP(STEP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .ctrl_i      (ctrl_i),
  .likely_i    (likely_i),
  .link_i      (link_i),
  .cond_i      (cond_i),
  .disp_i      (disp_i),
  .target_i    (target_i),
  .pc_o        (pc_o),
  .npc_o       (npc_o),
  .nnpc_o      (nnpc_o),
  .link_we_o   (link_we_o),
  .link_data_o (link_data_o),
  .annul_o     (annul_o)
);

// File: tb/tb_pc_seq_top.sv
`timescale 1ns/1ps
module tb_pc_seq_top;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        valid_i, likely_i, link_i, cond_i;
  logic [1:0]  ctrl_i;
  logic [31:0] disp_i, target_i;
  logic [31:0] pc_o, npc_o, nnpc_o, link_data_o;
  logic        link_we_o, annul_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] m_pc, m_npc, m_nnpc;

  always #2.5 clk_i = ~clk_i;

  pc_seq_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ctrl_i(ctrl_i),
    .likely_i(likely_i), .link_i(link_i), .cond_i(cond_i), .disp_i(disp_i),
    .target_i(target_i), .pc_o(pc_o), .npc_o(npc_o), .nnpc_o(nnpc_o),
    .link_we_o(link_we_o), .link_data_o(link_data_o), .annul_o(annul_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [1:0] ct, input bit lk,
                      input bit ln, input bit c, input logic [31:0] d,
                      input logic [31:0] t);
    logic [31:0] e_pc, e_npc, e_nnpc, tm;
    bit e_annul, e_we;
    string tag;
    @(negedge clk_i);
    valid_i = v; ctrl_i = ct; likely_i = lk; link_i = ln; cond_i = c;
    disp_i = d; target_i = t;
    #1;
    e_annul = v && ct == 2'd1 && lk && !c;
    e_we    = v && ln && ct != 2'd0;
    chk(annul_o == e_annul, e_annul ? "R5" : (ct == 2'd2 ? "R9" : "R4"),
        "annul", 32'(annul_o), 32'(e_annul));
    chk(link_we_o == e_we, v ? "R6" : "R8", "link_we", 32'(link_we_o), 32'(e_we));
    if (e_we) chk(link_data_o == m_nnpc, "R6", "link_data", link_data_o, m_nnpc);
    tm = t & 32'hFFFF_FFFC;
    e_pc = m_pc; e_npc = m_npc; e_nnpc = m_nnpc;
    if (!v) tag = "R8";
    else if (ct == 2'd0) begin
      tag = "R2"; e_pc = m_npc; e_npc = m_nnpc; e_nnpc = m_nnpc + 4;
    end else if (ct == 2'd3) begin
      tag = "R7"; e_pc = m_npc; e_npc = tm; e_nnpc = tm + 4;
    end else if (ct == 2'd2 || c) begin
      tag = (ct == 2'd2) ? "R9" : "R3";
      e_pc = m_npc; e_npc = m_npc + d; e_nnpc = m_npc + d + 4;
    end else if (lk) begin
      tag = "R5"; e_pc = m_nnpc; e_npc = m_nnpc + 4; e_nnpc = m_nnpc + 8;
    end else begin
      tag = "R4"; e_pc = m_npc; e_npc = m_nnpc; e_nnpc = m_nnpc + 4;
    end
    @(posedge clk_i);
    #1;
    chk(pc_o == e_pc, tag, "pc", pc_o, e_pc);
    chk(npc_o == e_npc, tag, "npc", npc_o, e_npc);
    chk(nnpc_o == e_nnpc, tag, "nnpc", nnpc_o, e_nnpc);
    m_pc = e_pc; m_npc = e_npc; m_nnpc = e_nnpc;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] disps [4];
    logic [31:0] tgts [4];
    disps[0] = 32'h0000_0010; disps[1] = 32'hFFFF_FFF0;
    disps[2] = 32'h0000_1000; disps[3] = 32'hFFFF_FF04;
    tgts[0]  = 32'h0000_4003; tgts[1]  = 32'h8000_1236;
    tgts[2]  = 32'h0000_0100; tgts[3]  = 32'hFFFF_FFF1;
    rst_ni = 1'b0; valid_i = 0; ctrl_i = 0; likely_i = 0; link_i = 0;
    cond_i = 0; disp_i = 0; target_i = 0;
    repeat (3) @(posedge clk_i);
    #1;
    chk(pc_o == 32'd0, "R1", "reset pc", pc_o, 32'd0);
    chk(npc_o == 32'd4, "R1", "reset npc", npc_o, 32'd4);
    chk(nnpc_o == 32'd8, "R1", "reset nnpc", nnpc_o, 32'd8);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk(pc_o == 32'd0 && npc_o == 32'd4 && nnpc_o == 32'd8, "R1", "post-reset pc",
        pc_o, 32'd0);
    m_pc = 32'd0; m_npc = 32'd4; m_nnpc = 32'd8;
    for (int r = 0; r < 4; r++)
      for (int v = 0; v < 2; v++)
        for (int ct = 0; ct < 4; ct++)
          for (int lk = 0; lk < 2; lk++)
            for (int ln = 0; ln < 2; ln++)
              for (int c = 0; c < 2; c++)
                step(v[0], 2'(ct), lk[0], ln[0], c[0], disps[(r + c) % 4], tgts[(r + ct) % 4]);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule